// File: doc/BRIEF.md
# Dual-Channel DMA Control and Interrupt Register Block

This block is the software-visible control point of a two-channel DMA engine. One channel moves data for a SCSI controller and the other for an Ethernet controller. A word-addressed bus port reaches eight 32-bit registers. The block drives one interrupt line per channel and one reset pulse per attached peripheral, and it presents each channel's transfer direction.

On the SCSI channel the block holds the current memory address. It advances that address by the byte count of each completed burst and flags completion in the control word. On the Ethernet channel the block forms each memory address by ORing a base register into the address the peripheral supplies. It can also exchange the two bytes of every 16-bit halfword on both data paths. The translation unit, the peripherals and memory sit outside the block, behind simple request and strobe ports.

Top module: `dual_dma_ctrl`

## Requirements
- R1: The bus port selects one of eight registers by word index (byte address bits [4:2]). A read returns the addressed register in the same cycle. A write to any index other than 0, 1 and 4 stores all 32 bits at the next clock edge.
- R2: After synchronous reset, indices 0 and 4 read 0xA0000000, every other register reads 0, and both interrupt lines and both reset pulses are low.
- R3: In the two control words (index 0 for SCSI, index 4 for Ethernet), bit 4 is the interrupt enable and bit 8 is the direction bit, where 1 means "peripheral writes to memory". Bit 8 of index 0 drives `scsi_to_mem` and bit 8 of index 4 drives `eth_to_mem`.
- R4: Writing a control word with bit 7 set raises that channel's reset output for exactly one cycle, in the cycle after the write. Bit 7 always reads back 0.
- R5: Every write to index 0 sets bit 26 of index 0, the address-loaded flag. Writes to index 4 do not set it.
- R6: A `scsi_xfer_done` strobe sets bit 0 (status) of index 0 and adds `scsi_xfer_len` to index 1, which drives `scsi_mem_addr`. When a bus write to index 1 lands in the same cycle, the written value wins.
- R7: `scsi_irq_set` sets status bit 0 of index 0 and `scsi_irq_clr` clears it. When both arrive in the same cycle, set wins. A bus write to index 0 loads bit 0 from the written data unless a set or clear arrives in the same cycle.
- R8: Each interrupt line is high exactly when its control word has both bit 0 and bit 4 set. Writing a control word with bit 4 clear drops the line from the next cycle.
- R9: For an Ethernet request, `eth_mem_addr` equals `eth_paddr` ORed with index 7. Both it and `eth_mem_req` are registered, so they appear one cycle after the request.
- R10: When `eth_swap` is high, both Ethernet data paths (`eth_wdata` to `eth_mem_wdata`, and `eth_mem_rdata` to `eth_rdata`) exchange the bytes of each 16-bit halfword. When it is low, the data passes unchanged. Both paths have one cycle of latency.
- R11: Bit 0 of index 4 copies `eth_irq_in` from the previous cycle. Bus writes to that bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word index (byte address bits [4:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| scsi_xfer_done | input | 1 | SCSI burst completed |
| scsi_xfer_len | input | 16 | Byte count of the completed burst |
| scsi_irq_set | input | 1 | SCSI peripheral raises its interrupt |
| scsi_irq_clr | input | 1 | SCSI peripheral clears its interrupt |
| scsi_mem_addr | output | 32 | Current SCSI memory address |
| scsi_to_mem | output | 1 | SCSI direction bit |
| scsi_irq | output | 1 | SCSI interrupt line |
| scsi_rst | output | 1 | One-cycle reset pulse to the SCSI peripheral |
| eth_req | input | 1 | Ethernet access request |
| eth_paddr | input | 32 | Peripheral-supplied address |
| eth_swap | input | 1 | Halfword byte exchange enable |
| eth_wdata | input | 32 | Data from the peripheral to memory |
| eth_mem_rdata | input | 32 | Data from memory to the peripheral |
| eth_irq_in | input | 1 | Ethernet peripheral interrupt level |
| eth_mem_req | output | 1 | Registered memory request |
| eth_mem_addr | output | 32 | Merged memory address |
| eth_mem_wdata | output | 32 | Data toward memory, optionally exchanged |
| eth_rdata | output | 32 | Data toward the peripheral, optionally exchanged |
| eth_to_mem | output | 1 | Ethernet direction bit |
| eth_irq | output | 1 | Ethernet interrupt line |
| eth_rst | output | 1 | One-cycle reset pulse to the Ethernet peripheral |

## Verification
The address advance is driven with an even burst length, then with an odd one that crosses no boundary, and then with a strobe that collides with a bus write to the address register, which shows whether the bus write takes priority. The Ethernet merge uses one base whose bits do not overlap the peripheral address and one whose bits partly overlap it, which separates a true OR from an add or a replace. The byte exchange uses a word with four distinct bytes, on both paths, with the exchange on and off, so that a full 32-bit reversal or a swap on only one path shows up. The interrupt tests drive set alone, clear alone, and both together, and they toggle the enable independently of the status bit.

// File: rtl/ddma_pkg.sv
package ddma_pkg;
  // control word bit positions
  localparam int B_STAT   = 0;
  localparam int B_IEN    = 4;
  localparam int B_RST    = 7;
  localparam int B_TOMEM  = 8;
  localparam int B_LOADED = 26;
  // register indices
  localparam int IDX_SCSI_CTL  = 0;
  localparam int IDX_SCSI_ADDR = 1;
  localparam int IDX_ETH_CTL   = 4;
  localparam int IDX_ETH_BASE  = 7;
endpackage

// File: rtl/ddma_ctrl_word.sv
module ddma_ctrl_word
  import ddma_pkg::*;
#(
  parameter int          DW          = 32,
  parameter logic [31:0] VERSION     = 32'hA000_0000,
  parameter int          SW_STAT     = 1,
  parameter int          MARK_LOADED = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          stat_set,
  input  logic          stat_clr,
  output logic [DW-1:0] q,
  output logic          irq,
  output logic          prst
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      nxt        = wdata;
      nxt[B_RST] = 1'b0;
      if (MARK_LOADED != 0) nxt[B_LOADED] = 1'b1;
      if (SW_STAT == 0)     nxt[B_STAT]   = q[B_STAT];
    end
    if (stat_set)      nxt[B_STAT] = 1'b1;
    else if (stat_clr) nxt[B_STAT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= DW'(VERSION);
      prst <= 1'b0;
    end else begin
      q    <= nxt;
      prst <= wr_en & wdata[B_RST];
    end
  end

  assign irq = q[B_STAT] & q[B_IEN];
endmodule

// File: rtl/ddma_addr_ctr.sv
module ddma_addr_ctr #(
  parameter int DW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             adv,
  input  logic [LEN_W-1:0] len,
  output logic [DW-1:0]    q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wdata;
    else if (adv)   q <= q + DW'(len);
  end
endmodule

// File: rtl/ddma_eth_path.sv
module ddma_eth_path #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [DW-1:0] paddr,
  input  logic [DW-1:0] base,
  input  logic          swap,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata_out
);
  localparam int NHALF = DW / 16;
  logic [DW-1:0] w_x, r_x;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign w_x[16*h +: 16] = {wdata_in[16*h +: 8], wdata_in[16*h+8 +: 8]};
    assign r_x[16*h +: 16] = {rdata_in[16*h +: 8], rdata_in[16*h+8 +: 8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rdata_out <= '0;
    end else begin
      mem_req   <= req;
      if (req) mem_addr <= paddr | base;
      mem_wdata <= swap ? w_x : wdata_in;
      rdata_out <= swap ? r_x : rdata_in;
    end
  end
endmodule

// File: rtl/dual_dma_ctrl.sv
module dual_dma_ctrl
  import ddma_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          NREG    = 8,
  parameter int          LEN_W   = 16,
  parameter logic [31:0] VERSION = 32'hA000_0000,
  localparam int         IDX_W   = $clog2(NREG),
  localparam int         WIN_AW  = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic [WIN_AW-1:2]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               scsi_xfer_done,
  input  logic [LEN_W-1:0]   scsi_xfer_len,
  input  logic               scsi_irq_set,
  input  logic               scsi_irq_clr,
  output logic [DW-1:0]      scsi_mem_addr,
  output logic               scsi_to_mem,
  output logic               scsi_irq,
  output logic               scsi_rst,
  input  logic               eth_req,
  input  logic [DW-1:0]      eth_paddr,
  input  logic               eth_swap,
  input  logic [DW-1:0]      eth_wdata,
  input  logic [DW-1:0]      eth_mem_rdata,
  input  logic               eth_irq_in,
  output logic               eth_mem_req,
  output logic [DW-1:0]      eth_mem_addr,
  output logic [DW-1:0]      eth_mem_wdata,
  output logic [DW-1:0]      eth_rdata,
  output logic               eth_to_mem,
  output logic               eth_irq,
  output logic               eth_rst
);
  logic [DW-1:0] rview [NREG];
  logic [DW-1:0] scsi_ctl_q, eth_ctl_q;

  function automatic logic hit(input logic [IDX_W-1:0] a, input int idx);
    return a == IDX_W'(idx);
  endfunction

  ddma_ctrl_word #(.DW(DW), .VERSION(VERSION), .SW_STAT(1), .MARK_LOADED(1)) u_scsi_ctl (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && hit(bus_addr, IDX_SCSI_CTL)), .wdata(bus_wdata),
    .stat_set(scsi_xfer_done | scsi_irq_set), .stat_clr(scsi_irq_clr),
    .q(scsi_ctl_q), .irq(scsi_irq), .prst(scsi_rst)
  );

  ddma_ctrl_word #(.DW(DW), .VERSION(VERSION), .SW_STAT(0), .MARK_LOADED(0)) u_eth_ctl (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && hit(bus_addr, IDX_ETH_CTL)), .wdata(bus_wdata),
    .stat_set(eth_irq_in), .stat_clr(~eth_irq_in),
    .q(eth_ctl_q), .irq(eth_irq), .prst(eth_rst)
  );

  ddma_addr_ctr #(.DW(DW), .LEN_W(LEN_W)) u_scsi_addr (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && hit(bus_addr, IDX_SCSI_ADDR)), .wdata(bus_wdata),
    .adv(scsi_xfer_done), .len(scsi_xfer_len), .q(scsi_mem_addr)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_SCSI_CTL) begin : g_sc
      assign rview[i] = scsi_ctl_q;
    end else if (i == IDX_SCSI_ADDR) begin : g_sa
      assign rview[i] = scsi_mem_addr;
    end else if (i == IDX_ETH_CTL) begin : g_ec
      assign rview[i] = eth_ctl_q;
    end else begin : g_plain
      logic [DW-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                               r <= '0;
        else if (bus_we && hit(bus_addr, i))   r <= bus_wdata;
      end
      assign rview[i] = r;
    end
  end

  ddma_eth_path #(.DW(DW)) u_eth_path (
    .clk(clk), .rst(rst),
    .req(eth_req), .paddr(eth_paddr), .base(rview[IDX_ETH_BASE]),
    .swap(eth_swap), .wdata_in(eth_wdata), .rdata_in(eth_mem_rdata),
    .mem_req(eth_mem_req), .mem_addr(eth_mem_addr),
    .mem_wdata(eth_mem_wdata), .rdata_out(eth_rdata)
  );

  assign bus_rdata   = rview[bus_addr];
  assign scsi_to_mem = scsi_ctl_q[B_TOMEM];
  assign eth_to_mem  = eth_ctl_q[B_TOMEM];
endmodule

// File: rtl/ddma_checker.sv
module ddma_checker
  import ddma_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 3,
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [IDX_W-1:0] bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             scsi_xfer_done,
  input logic [LEN_W-1:0] scsi_xfer_len,
  input logic             scsi_irq_set,
  input logic             scsi_irq_clr,
  input logic [DW-1:0]    scsi_mem_addr,
  input logic             scsi_irq,
  input logic             scsi_rst,
  input logic             eth_req,
  input logic [DW-1:0]    eth_paddr,
  input logic             eth_irq_in,
  input logic             eth_mem_req,
  input logic [DW-1:0]    eth_mem_addr,
  input logic             eth_irq,
  input logic             eth_rst
);
  logic wr_ctl0, wr_addr1, wr_ctl4;
  assign wr_ctl0  = bus_we && bus_addr == IDX_W'(IDX_SCSI_CTL);
  assign wr_addr1 = bus_we && bus_addr == IDX_W'(IDX_SCSI_ADDR);
  assign wr_ctl4  = bus_we && bus_addr == IDX_W'(IDX_ETH_CTL);

  assert_rst_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    scsi_rst |=> !scsi_rst);
  assert_eth_rst_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    eth_rst |=> !eth_rst);
  assert_loaded_R5: assert property (@(posedge clk) disable iff (rst)
    wr_ctl0 |=> (bus_addr != IDX_W'(IDX_SCSI_CTL) || bus_rdata[B_LOADED]));
  assert_addr_adv_R6: assert property (@(posedge clk) disable iff (rst)
    (scsi_xfer_done && !wr_addr1) |=>
      scsi_mem_addr == $past(scsi_mem_addr) + DW'($past(scsi_xfer_len)));
  assert_irq_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (scsi_irq_clr && !scsi_irq_set && !scsi_xfer_done) |=> !scsi_irq);
  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl0 && !bus_wdata[B_IEN]) |=> !scsi_irq);
  assert_eth_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl4 && !bus_wdata[B_IEN]) |=> !eth_irq);
  assert_eth_or_R9: assert property (@(posedge clk) disable iff (rst)
    eth_req |=> (eth_mem_req && ((eth_mem_addr & $past(eth_paddr)) == $past(eth_paddr))));
  assert_eth_irq_src_R11: assert property (@(posedge clk) disable iff (rst)
    eth_irq |-> $past(eth_irq_in));
endmodule

bind dual_dma_ctrl ddma_checker #(.DW(DW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .scsi_xfer_done(scsi_xfer_done), .scsi_xfer_len(scsi_xfer_len),
  .scsi_irq_set(scsi_irq_set), .scsi_irq_clr(scsi_irq_clr),
  .scsi_mem_addr(scsi_mem_addr), .scsi_irq(scsi_irq), .scsi_rst(scsi_rst),
  .eth_req(eth_req), .eth_paddr(eth_paddr), .eth_irq_in(eth_irq_in),
  .eth_mem_req(eth_mem_req), .eth_mem_addr(eth_mem_addr),
  .eth_irq(eth_irq), .eth_rst(eth_rst)
);

// File: tb/dual_dma_ctrl_tb.sv
module dual_dma_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scsi_xfer_done = 1'b0;
  logic [15:0] scsi_xfer_len = '0;
  logic        scsi_irq_set = 1'b0, scsi_irq_clr = 1'b0;
  logic [31:0] scsi_mem_addr;
  logic        scsi_to_mem, scsi_irq, scsi_rst;
  logic        eth_req = 1'b0;
  logic [31:0] eth_paddr = '0;
  logic        eth_swap = 1'b0;
  logic [31:0] eth_wdata = '0, eth_mem_rdata = '0;
  logic        eth_irq_in = 1'b0;
  logic        eth_mem_req;
  logic [31:0] eth_mem_addr, eth_mem_wdata, eth_rdata;
  logic        eth_to_mem, eth_irq, eth_rst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dma_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scsi_xfer_done(scsi_xfer_done), .scsi_xfer_len(scsi_xfer_len),
    .scsi_irq_set(scsi_irq_set), .scsi_irq_clr(scsi_irq_clr),
    .scsi_mem_addr(scsi_mem_addr), .scsi_to_mem(scsi_to_mem),
    .scsi_irq(scsi_irq), .scsi_rst(scsi_rst),
    .eth_req(eth_req), .eth_paddr(eth_paddr), .eth_swap(eth_swap),
    .eth_wdata(eth_wdata), .eth_mem_rdata(eth_mem_rdata), .eth_irq_in(eth_irq_in),
    .eth_mem_req(eth_mem_req), .eth_mem_addr(eth_mem_addr),
    .eth_mem_wdata(eth_mem_wdata), .eth_rdata(eth_rdata),
    .eth_to_mem(eth_to_mem), .eth_irq(eth_irq), .eth_rst(eth_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'(idx); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [31:0] d);
    bus_addr = 3'(idx);
    #1 d = bus_rdata;
  endtask

  task automatic scsi_ev(input logic done, input logic [15:0] len, input logic s, input logic c);
    @(negedge clk);
    scsi_xfer_done = done; scsi_xfer_len = len; scsi_irq_set = s; scsi_irq_clr = c;
    @(posedge clk); #1;
    scsi_xfer_done = 1'b0; scsi_irq_set = 1'b0; scsi_irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      bus_read(i, d);
      chk((i == 0 || i == 4) ? "R2 version word" : "R2 zero word", d,
          (i == 0 || i == 4) ? 32'hA000_0000 : 32'h0);
    end
    chk("R2 irq lines", {30'd0, scsi_irq, eth_irq}, 32'h0);
    chk("R2 reset pulses", {30'd0, scsi_rst, eth_rst}, 32'h0);
  endtask

  task automatic t_plain_rw();
    logic [31:0] d;
    bus_write(2, 32'hDEAD_BEEF);
    bus_write(3, 32'h0123_4567);
    bus_write(5, 32'hFFFF_0000);
    bus_write(6, 32'h8000_0001);
    bus_read(2, d); chk("R1 idx2", d, 32'hDEAD_BEEF);
    bus_read(3, d); chk("R1 idx3", d, 32'h0123_4567);
    bus_read(5, d); chk("R1 idx5", d, 32'hFFFF_0000);
    bus_read(6, d); chk("R1 idx6", d, 32'h8000_0001);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] d;
    bus_write(0, 32'h0000_0110);
    bus_read(0, d); chk("R5 loaded flag on idx0", d, 32'h0400_0110);
    chk("R3 scsi direction", {31'd0, scsi_to_mem}, 32'h1);
    bus_write(4, 32'h0000_0100);
    bus_read(4, d); chk("R5 no loaded flag on idx4", d, 32'h0000_0100);
    chk("R3 eth direction", {31'd0, eth_to_mem}, 32'h1);
    bus_write(0, 32'h0000_0010);
    chk("R3 scsi direction cleared", {31'd0, scsi_to_mem}, 32'h0);
  endtask

  task automatic t_reset_cmd();
    logic [31:0] d;
    bus_write(0, 32'h0000_0090);
    chk("R4 scsi pulse high", {31'd0, scsi_rst}, 32'h1);
    chk("R4 eth pulse idle", {31'd0, eth_rst}, 32'h0);
    @(posedge clk); #1;
    chk("R4 scsi pulse one cycle", {31'd0, scsi_rst}, 32'h0);
    bus_read(0, d); chk("R4 bit7 not kept", d, 32'h0400_0010);
    bus_write(4, 32'h0000_0080);
    chk("R4 eth pulse high", {31'd0, eth_rst}, 32'h1);
    @(posedge clk); #1;
    chk("R4 eth pulse one cycle", {31'd0, eth_rst}, 32'h0);
    bus_read(4, d); chk("R4 eth bit7 not kept", d, 32'h0);
  endtask

  task automatic t_xfer();
    logic [31:0] d;
    bus_write(1, 32'h0000_1000);
    scsi_ev(1'b1, 16'h0020, 1'b0, 1'b0);
    chk("R6 advance by 0x20", scsi_mem_addr, 32'h0000_1020);
    bus_read(0, d); chk("R6 status set", d & 32'h1, 32'h1);
    chk("R8 irq with enable", {31'd0, scsi_irq}, 32'h1);
    scsi_ev(1'b1, 16'h0001, 1'b0, 1'b0);
    chk("R6 advance by 1", scsi_mem_addr, 32'h0000_1021);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd1; bus_wdata = 32'h0000_8000;
    scsi_xfer_done = 1'b1; scsi_xfer_len = 16'h0004;
    @(posedge clk); #1;
    bus_we = 1'b0; scsi_xfer_done = 1'b0;
    chk("R6 bus write wins", scsi_mem_addr, 32'h0000_8000);
    bus_read(1, d); chk("R6 idx1 readback", d, 32'h0000_8000);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(0, 32'h0000_0010);
    chk("R7 write clears status", {31'd0, scsi_irq}, 32'h0);
    scsi_ev(1'b0, 16'h0, 1'b1, 1'b0);
    chk("R7 set raises line", {31'd0, scsi_irq}, 32'h1);
    bus_read(0, d); chk("R7 status bit", d, 32'h0400_0011);
    scsi_ev(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R7 clear drops line", {31'd0, scsi_irq}, 32'h0);
    scsi_ev(1'b0, 16'h0, 1'b1, 1'b1);
    chk("R7 set wins over clear", {31'd0, scsi_irq}, 32'h1);
    bus_write(0, 32'h0000_0001);
    chk("R8 enable off drops line", {31'd0, scsi_irq}, 32'h0);
    bus_read(0, d); chk("R8 status kept", d, 32'h0400_0001);
    bus_write(0, 32'h0000_0011);
    chk("R8 enable on raises line", {31'd0, scsi_irq}, 32'h1);
    scsi_ev(1'b0, 16'h0, 1'b0, 1'b1);
    chk("R7 clear again", {31'd0, scsi_irq}, 32'h0);
  endtask

  task automatic t_eth_addr();
    bus_write(7, 32'hF000_0000);
    @(negedge clk); eth_req = 1'b1; eth_paddr = 32'h0000_1234;
    @(posedge clk); #1; eth_req = 1'b0;
    chk("R9 req registered", {31'd0, eth_mem_req}, 32'h1);
    chk("R9 disjoint merge", eth_mem_addr, 32'hF000_1234);
    @(posedge clk); #1;
    chk("R9 req drops", {31'd0, eth_mem_req}, 32'h0);
    bus_write(7, 32'h00FF_0000);
    @(negedge clk); eth_req = 1'b1; eth_paddr = 32'h0F0F_0F0F;
    @(posedge clk); #1; eth_req = 1'b0;
    chk("R9 overlapping merge", eth_mem_addr, 32'h0FFF_0F0F);
  endtask

  task automatic t_swap();
    @(negedge clk);
    eth_swap = 1'b1; eth_wdata = 32'h1122_3344; eth_mem_rdata = 32'hA1B2_C3D4;
    @(posedge clk); #1;
    chk("R10 write path swapped", eth_mem_wdata, 32'h2211_4433);
    chk("R10 read path swapped", eth_rdata, 32'hB2A1_D4C3);
    @(negedge clk); eth_swap = 1'b0;
    @(posedge clk); #1;
    chk("R10 write path plain", eth_mem_wdata, 32'h1122_3344);
    chk("R10 read path plain", eth_rdata, 32'hA1B2_C3D4);
  endtask

  task automatic t_eth_irq();
    logic [31:0] d;
    bus_write(4, 32'h0000_0010);
    @(negedge clk); eth_irq_in = 1'b1;
    @(posedge clk); #1;
    chk("R11 status follows input", {31'd0, eth_irq}, 32'h1);
    bus_write(4, 32'h0000_0010);
    bus_read(4, d); chk("R11 write of 0 ignored", d, 32'h0000_0011);
    bus_write(4, 32'h0000_0000);
    chk("R8 eth enable off", {31'd0, eth_irq}, 32'h0);
    @(negedge clk); eth_irq_in = 1'b0;
    @(posedge clk); #1;
    bus_write(4, 32'h0000_0011);
    bus_read(4, d); chk("R11 write of 1 ignored", d, 32'h0000_0010);
    chk("R11 line low", {31'd0, eth_irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    t_reset();
    t_plain_rw();
    t_ctrl_bits();
    t_reset_cmd();
    t_xfer();
    t_irq();
    t_eth_addr();
    t_swap();
    t_eth_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule